// File: doc/BRIEF.md
# Mode-0 Parallel Port Interface

This block is a programmable parallel I/O peripheral with three 8-bit ports (A, B and C) that works only in the plain input/output mode. A host reaches it through I/O-mapped accesses: a 16-bit port address, an 8-bit write bus, an 8-bit read bus, and read and write strobes. Writes take effect on the rising clock edge. Reads are combinational.

A control word sets the direction of four groups: port A, port B, the upper half of port C and the lower half of port C. A second control word format sets or clears one bit of port C without touching the other bits. Each port has a pad input bus, an output latch bus and a per-bit output enable, so the block can drive bidirectional pads through external buffers.

Top module: `ppi_mode0`

## Requirements
- R1: After reset, every output enable is 0, every output latch is 0x00, and all four port groups are inputs.
- R2: An access with `io_addr[11]` = 1 is ignored. A write changes no latch and no direction. A read returns 0xFF.
- R3: With `io_addr[11]` = 0, `io_addr[9:8]` picks the register: 0 is port A, 1 is port B, 2 is port C, 3 is control. All other address bits have no effect.
- R4: A control write with bit 7 = 1 sets the directions, where a bit value of 1 means input. Bit 4 controls port A, bit 3 controls C[7:4], bit 1 controls port B and bit 0 controls C[3:0]. An output group drives its output enables to all ones. An input group drives them to zeros.
- R5: Every control write with bit 7 = 1 clears the latches of A, B and C to 0x00.
- R6: A control write with bit 7 = 0 writes bit 0 of the word into port C latch bit `wr_data[3:1]`. All other latch bits and all directions are left unchanged.
- R7: A data read returns the pad value for each bit in an input group and the latch value for each bit in an output group. Port C is resolved per nibble.
- R8: A read of the control address returns 0xFF.
- R9: When `rd_en` is 0, `rd_data` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 16 | Host I/O port address |
| wr_data | input | 8 | Host write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Host read data |
| pa_in | input | 8 | Port A pad input |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enable |
| pb_in | input | 8 | Port B pad input |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enable |
| pc_in | input | 8 | Port C pad input |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enable |

## Verification
The bench sets port C to mixed nibble directions and reads it back. A design that resolved direction per port rather than per nibble would return pad bits where latch bits are expected. It writes and reads with bit 11 high and with random values in the unused address bits. A decoder that ignored bit 11, or that decoded too many bits, would corrupt latches or miss accesses. It issues bit set/reset words for the highest bit index and for a clear. A design that treated those words as mode words would change the directions and clear the latches. It also issues a second mode word after the latches have been loaded, to show they are cleared.

// File: rtl/ppi_mode0.sv
module ppi_mode0 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic [7:0]  wr_data,
  input  logic        wr_en,
  input  logic        rd_en,
  output logic [7:0]  rd_data,
  input  logic [7:0]  pa_in,
  output logic [7:0]  pa_out,
  output logic [7:0]  pa_oe,
  input  logic [7:0]  pb_in,
  output logic [7:0]  pb_out,
  output logic [7:0]  pb_oe,
  input  logic [7:0]  pc_in,
  output logic [7:0]  pc_out,
  output logic [7:0]  pc_oe
);
  logic       sel;
  logic [1:0] reg_sel;
  logic       a_inp, b_inp, cu_inp, cl_inp;
  logic [7:0] a_lat, b_lat, c_lat;
  logic [7:0] c_rd;

  assign sel     = ~io_addr[11];
  assign reg_sel = io_addr[9:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_inp  <= 1'b1;
      b_inp  <= 1'b1;
      cu_inp <= 1'b1;
      cl_inp <= 1'b1;
      a_lat  <= '0;
      b_lat  <= '0;
      c_lat  <= '0;
    end else if (wr_en && sel) begin
      case (reg_sel)
        2'd0: a_lat <= wr_data;
        2'd1: b_lat <= wr_data;
        2'd2: c_lat <= wr_data;
        default: begin
          if (wr_data[7]) begin
            a_inp  <= wr_data[4];
            cu_inp <= wr_data[3];
            b_inp  <= wr_data[1];
            cl_inp <= wr_data[0];
            a_lat  <= '0;
            b_lat  <= '0;
            c_lat  <= '0;
          end else begin
            c_lat[wr_data[3:1]] <= wr_data[0];
          end
        end
      endcase
    end
  end

  assign pa_out = a_lat;
  assign pb_out = b_lat;
  assign pc_out = c_lat;
  assign pa_oe  = {8{~a_inp}};
  assign pb_oe  = {8{~b_inp}};
  assign pc_oe  = {{4{~cu_inp}}, {4{~cl_inp}}};

  assign c_rd[7:4] = cu_inp ? pc_in[7:4] : c_lat[7:4];
  assign c_rd[3:0] = cl_inp ? pc_in[3:0] : c_lat[3:0];

  always_comb begin
    rd_data = 8'hFF;
    if (rd_en && sel) begin
      case (reg_sel)
        2'd0:    rd_data = a_inp ? pa_in : a_lat;
        2'd1:    rd_data = b_inp ? pb_in : b_lat;
        2'd2:    rd_data = c_rd;
        default: rd_data = 8'hFF;
      endcase
    end
  end
endmodule

// File: rtl/ppi_mode0_chk.sv
module ppi_mode0_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic [7:0]  wr_data,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  rd_data,
  input logic [7:0]  pa_in,
  input logic [7:0]  pa_out,
  input logic [7:0]  pa_oe,
  input logic [7:0]  pb_out,
  input logic [7:0]  pb_oe,
  input logic [7:0]  pc_out,
  input logic [7:0]  pc_oe
);
  logic ctl_wr;
  assign ctl_wr = wr_en && !io_addr[11] && io_addr[9:8] == 2'd3;

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00 &&
                      pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  a_r2_ignore_unsel: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && io_addr[11]) |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                               $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  a_r5_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wr_data[7]) |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  a_r6_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wr_data[7]) |=> ($countones(pc_out ^ $past(pc_out)) <= 1 &&
                                $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) &&
                                $stable(pa_out) && $stable(pb_out)));

  a_r7_input_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !io_addr[11] && io_addr[9:8] == 2'd0 && pa_oe == 8'h00) |-> rd_data == pa_in);

  a_r8_ctrl_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !io_addr[11] && io_addr[9:8] == 2'd3) |-> rd_data == 8'hFF);

  a_r9_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == 8'hFF);
endmodule

bind ppi_mode0 ppi_mode0_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .wr_data(wr_data),
  .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .pa_in(pa_in),
  .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
  .pc_out(pc_out), .pc_oe(pc_oe)
);

// File: tb/sim_ppi_mode0.sv
module sim_ppi_mode0;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] io_addr = 16'hFFFF;
  logic [7:0]  wr_data = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  rd_data, pa_in = 8'h3C, pb_in = 8'hA5, pc_in = 8'h96;
  logic [7:0]  pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppi_mode0 u0 (.clk(clk), .rst_n(rst_n), .io_addr(io_addr), .wr_data(wr_data),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .pa_in(pa_in), .pa_out(pa_out),
    .pa_oe(pa_oe), .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in),
    .pc_out(pc_out), .pc_oe(pc_oe));

  // reference model
  bit a_i, b_i, cu_i, cl_i;
  logic [7:0] ma, mb, mc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_i = 1; b_i = 1; cu_i = 1; cl_i = 1; ma = 0; mb = 0; mc = 0;
    end else if (wr_en && io_addr[11] == 0) begin
      if (io_addr[9:8] == 0) ma = wr_data;
      else if (io_addr[9:8] == 1) mb = wr_data;
      else if (io_addr[9:8] == 2) mc = wr_data;
      else if (wr_data[7]) begin
        a_i = wr_data[4]; cu_i = wr_data[3]; b_i = wr_data[1]; cl_i = wr_data[0];
        ma = 0; mb = 0; mc = 0;
      end else mc[int'(wr_data[3:1])] = wr_data[0];
    end
  end

  function automatic logic [7:0] exp_rd();
    logic [7:0] r;
    if (!rd_en || io_addr[11]) return 8'hFF;
    case (io_addr[9:8])
      0: r = a_i ? pa_in : ma;
      1: r = b_i ? pb_in : mb;
      2: begin
        r[7:4] = cu_i ? pc_in[7:4] : mc[7:4];
        r[3:0] = cl_i ? pc_in[3:0] : mc[3:0];
      end
      default: r = 8'hFF;
    endcase
    return r;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R4 oe", {pa_oe, pb_oe} == {{8{~a_i}}, {8{~b_i}}} ? 8'h00 : 8'h01, 8'h00);
    chk("R4 pc_oe", pc_oe, {{4{~cu_i}}, {4{~cl_i}}});
    chk("R6 latches", (pa_out == ma && pb_out == mb) ? pc_out : ~mc, mc);
    chk("R7 rd", rd_data, exp_rd());
  end

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(posedge clk); #1;
    io_addr = a; wr_data = d; wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0; io_addr = 16'hFFFF;
  endtask

  task automatic rd(string tag, logic [15:0] a, logic [7:0] exp);
    @(posedge clk); #1;
    io_addr = a; rd_en = 1;
    @(negedge clk);
    chk(tag, rd_data, exp);
    @(posedge clk); #1;
    rd_en = 0; io_addr = 16'hFFFF;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 oe", pa_oe | pb_oe | pc_oe, 8'h00);
    chk("R1 out", pa_out | pb_out | pc_out, 8'h00);
    rd("R1 input A", 16'hF4FF, 8'h3C);
    rd("R8 ctrl", 16'hF7FF, 8'hFF);
    wr(16'hF7FF, 8'h82);
    @(negedge clk);
    chk("R4 0x82 A", pa_oe, 8'hFF);
    chk("R4 0x82 B", pb_oe, 8'h00);
    chk("R4 0x82 C", pc_oe, 8'hFF);
    wr(16'h00AB, 8'h5A);
    rd("R3 A alias", 16'h04CD, 8'h5A);
    wr(16'hF4FF, 8'hC3);
    wr(16'hFCFF, 8'h11);
    rd("R2 latch kept", 16'hF4FF, 8'hC3);
    rd("R2 read unsel", 16'hFC00, 8'hFF);
    wr(16'hFFFF, 8'h92);
    rd("R2 mode ignored", 16'hF4FF, 8'hC3);
    rd("R7 B input", 16'hF5FF, 8'hA5);
    wr(16'hF6FF, 8'h00);
    wr(16'hF7FF, 8'h0F);
    rd("R6 set bit7", 16'hF6FF, 8'h80);
    wr(16'hF7FF, 8'h03);
    rd("R6 set bit1", 16'hF6FF, 8'h82);
    wr(16'hF7FF, 8'h0E);
    rd("R6 clear bit7", 16'hF6FF, 8'h02);
    @(negedge clk);
    chk("R6 dir kept", pa_oe, 8'hFF);
    wr(16'hF6FF, 8'hF0);
    wr(16'hF7FF, 8'h92);
    @(negedge clk);
    chk("R5 cleared A", pa_out, 8'h00);
    chk("R5 cleared C", pc_out, 8'h00);
    chk("R4 0x92 A", pa_oe, 8'h00);
    wr(16'hF7FF, 8'h88);
    wr(16'hF6FF, 8'h5A);
    rd("R7 C mixed", 16'hF6FF, 8'h9A);
    wr(16'hF7FF, 8'h81);
    wr(16'hF6FF, 8'h5A);
    rd("R7 C mixed2", 16'hF6FF, 8'h56);
    wr(16'hF5FF, 8'h77);
    rd("R7 B out", 16'hF5FF, 8'h77);
    @(negedge clk);
    chk("R9 idle", rd_data, 8'hFF);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule